// File: doc/BRIEF.md
# Bridge Interrupt Aggregator

This block collects eleven level-sensitive interrupt lines from devices behind a bus bridge and turns them into one processor interrupt. It synchronises each line, watches for assertion edges, and when an enabled line asserts, it records a request and issues one outbound write. That write carries a programmed data word to a programmed target address over a ready/valid handshake.

Software reaches six word registers through a single-cycle read/write strobe interface. The registers are an enable mask, a read-to-clear request register, a read-to-clear pending register, a live level register, the target register and a retrigger register. The block raises requests on edges only. To treat a source as level-triggered, software reads the level register after servicing it and, if the line is still high, writes the retrigger register to force another delivery.

Top module: `bridge_irq_agg`

## Requirements
- R1: After reset the mask, request, pending and target registers read 0 and `msg_valid` is low.
- R2: Register index 3 (level) returns the two-flop-synchronised state of all eleven inputs in bits 10:0. Reading it changes no other register.
- R3: An assertion edge (0 to 1) of a synchronised input whose mask bit is 1 sets that bit in the request register (index 0). An input that is already high when its mask bit is set does not set a request.
- R4: An assertion edge on an input whose mask bit is 0 sets no request bit and starts no delivery. The mask is register index 1, and bit n enables input n.
- R5: Only the bits in 0x5FF are implemented in the request register. Bit 9 always reads 0 there, and an edge on input 9 never starts a delivery.
- R6: A read of the request register returns the latched bits and clears them in the same cycle. An edge that is latched in that same cycle is kept for the next read.
- R7: The pending register (index 2) records assertion edges of every input whatever the mask. A read returns and clears it and leaves the level register unchanged.
- R8: Each delivery is one write with `msg_addr` equal to the target register (index 4) with bits 4:0 forced to 0, and `msg_data` equal to target bits 4:0 zero-extended. It is issued in the cycle after the request is latched.
- R9: While `msg_valid` is high and `msg_ready` is low, `msg_addr` and `msg_data` hold steady. New requests merge into the outstanding write, so exactly one write completes.
- R10: A write to register index 5 (retrigger) causes exactly one delivery, whatever its data.
- R11: Reads return data one cycle after the read strobe and hold it until the next read. Reads of indices 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_irq | input | 11 | Asynchronous interrupt lines, one bit per source |
| csr_wr | input | 1 | Register write strobe |
| csr_rd | input | 1 | Register read strobe |
| csr_idx | input | 3 | Register index |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data, valid the cycle after `csr_rd` |
| msg_valid | output | 1 | Outbound write request valid |
| msg_ready | input | 1 | Outbound write accepted |
| msg_addr | output | 32 | Outbound write address |
| msg_data | output | 32 | Outbound write data |

## Verification
The bench raises a line while it is masked and then unmasks it. A design that latched levels instead of edges would post a request and a delivery there. It holds the ready line low while a second source fires: a block that queued instead of merging would complete two writes, and one that reloaded its address would change the address mid-handshake. It places a request-register read in exactly the cycle a new edge is latched. A naive clear would lose that edge, so the follow-up read would show zero. Edges on input 9 check that the unimplemented bit neither reads back nor triggers delivery.

// File: rtl/bia_pkg.sv
package bia_pkg;
  localparam int NSRC      = 11;
  localparam int IDX_W     = 3;
  localparam int WORD_W    = 32;
  localparam int DATA_BITS = 5;
  localparam logic [NSRC-1:0] IMPL_BITS = 11'h5FF;

  localparam logic [IDX_W-1:0] IDX_REQ    = 3'd0;
  localparam logic [IDX_W-1:0] IDX_MASK   = 3'd1;
  localparam logic [IDX_W-1:0] IDX_PEND   = 3'd2;
  localparam logic [IDX_W-1:0] IDX_LEVEL  = 3'd3;
  localparam logic [IDX_W-1:0] IDX_TARGET = 3'd4;
  localparam logic [IDX_W-1:0] IDX_KICK   = 3'd5;

  // Address part of the target word: low data field forced to zero.
  function automatic logic [WORD_W-1:0] tgt_addr(input logic [WORD_W-1:0] t);
    return {t[WORD_W-1:DATA_BITS], {DATA_BITS{1'b0}}};
  endfunction

  // Data part of the target word, zero-extended.
  function automatic logic [WORD_W-1:0] tgt_data(input logic [WORD_W-1:0] t);
    return {{(WORD_W-DATA_BITS){1'b0}}, t[DATA_BITS-1:0]};
  endfunction

  function automatic logic [WORD_W-1:0] widen(input logic [NSRC-1:0] v);
    return {{(WORD_W-NSRC){1'b0}}, v};
  endfunction
endpackage

// File: rtl/bia_sync.sv
module bia_sync #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta <= 1'b0;
        q[i] <= 1'b0;
      end else begin
        meta <= d[i];
        q[i] <= meta;
      end
    end
  end
endmodule

// File: rtl/bia_latch.sv
module bia_latch #(
  parameter int          W    = 11,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] mask,
  input  logic         clr_req,
  input  logic         clr_pend,
  output logic [W-1:0] req,
  output logic [W-1:0] pend,
  output logic [W-1:0] hit,
  output logic         any_hit
);
  logic [W-1:0] lvl_q;
  logic [W-1:0] rise;

  assign rise    = lvl & ~lvl_q;
  assign hit     = rise & mask & IMPL;
  assign any_hit = |hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      req   <= '0;
      pend  <= '0;
    end else begin
      lvl_q <= lvl;
      req   <= (clr_req  ? '0 : req)  | hit;
      pend  <= (clr_pend ? '0 : pend) | rise;
    end
  end
endmodule

// File: rtl/bia_deliver.sv
module bia_deliver
  import bia_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [WORD_W-1:0] target,
  input  logic              msg_ready,
  output logic              msg_valid,
  output logic [WORD_W-1:0] msg_addr,
  output logic [WORD_W-1:0] msg_data,
  output logic              issue
);
  assign issue = fire && (!msg_valid || msg_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (issue) begin
      msg_valid <= 1'b1;
      msg_addr  <= tgt_addr(target);
      msg_data  <= tgt_data(target);
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bridge_irq_agg.sv
module bridge_irq_agg
  import bia_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_irq,
  input  logic              csr_wr,
  input  logic              csr_rd,
  input  logic [IDX_W-1:0]  csr_idx,
  input  logic [WORD_W-1:0] csr_wdata,
  output logic [WORD_W-1:0] csr_rdata,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [WORD_W-1:0] msg_addr,
  output logic [WORD_W-1:0] msg_data
);
  logic [NSRC-1:0]   level;
  logic [NSRC-1:0]   mask_q;
  logic [WORD_W-1:0] target_q;
  logic [NSRC-1:0]   req_q;
  logic [NSRC-1:0]   pend_q;
  logic [NSRC-1:0]   hit;
  logic              any_hit;
  logic              rd_req, rd_pend, kick, fire, issue;

  assign rd_req  = csr_rd && (csr_idx == IDX_REQ);
  assign rd_pend = csr_rd && (csr_idx == IDX_PEND);
  assign kick    = csr_wr && (csr_idx == IDX_KICK);
  assign fire    = any_hit || kick;

  bia_sync #(.W(NSRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(src_irq), .q(level)
  );

  bia_latch #(.W(NSRC), .IMPL(IMPL_BITS)) u_latch (
    .clk(clk), .rst_n(rst_n), .lvl(level), .mask(mask_q),
    .clr_req(rd_req), .clr_pend(rd_pend),
    .req(req_q), .pend(pend_q), .hit(hit), .any_hit(any_hit)
  );

  bia_deliver u_dlv (
    .clk(clk), .rst_n(rst_n), .fire(fire), .target(target_q),
    .msg_ready(msg_ready), .msg_valid(msg_valid),
    .msg_addr(msg_addr), .msg_data(msg_data), .issue(issue)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      target_q <= '0;
    end else if (csr_wr) begin
      if (csr_idx == IDX_MASK)   mask_q   <= csr_wdata[NSRC-1:0];
      if (csr_idx == IDX_TARGET) target_q <= csr_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_rdata <= '0;
    end else if (csr_rd) begin
      case (csr_idx)
        IDX_REQ:    csr_rdata <= widen(req_q);
        IDX_MASK:   csr_rdata <= widen(mask_q);
        IDX_PEND:   csr_rdata <= widen(pend_q);
        IDX_LEVEL:  csr_rdata <= widen(level);
        IDX_TARGET: csr_rdata <= target_q;
        default:    csr_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/bia_chk.sv
module bia_chk
  import bia_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [WORD_W-1:0] msg_addr,
  input logic [WORD_W-1:0] msg_data,
  input logic              fire,
  input logic              issue,
  input logic [NSRC-1:0]   req,
  input logic [NSRC-1:0]   hit,
  input logic [NSRC-1:0]   level,
  input logic              csr_rd,
  input logic [IDX_W-1:0]  csr_idx,
  input logic [WORD_W-1:0] csr_rdata
);
  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

  p_no_reissue_r9: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |-> !issue);

  p_fire_delivers_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> msg_valid);

  p_unimpl_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req & ~IMPL_BITS) == '0);

  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rd && csr_idx == IDX_REQ && hit == '0 |=> req == '0);

  p_level_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rd && csr_idx == IDX_LEVEL |=> csr_rdata == widen($past(level)));
endmodule

bind bridge_irq_agg bia_chk u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_addr(msg_addr), .msg_data(msg_data), .fire(fire), .issue(issue),
  .req(req_q), .hit(hit), .level(level), .csr_rd(csr_rd),
  .csr_idx(csr_idx), .csr_rdata(csr_rdata)
);

// File: tb/bridge_irq_agg_tb.sv
module bridge_irq_agg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] src_irq = '0;
  logic        csr_wr = 1'b0, csr_rd = 1'b0;
  logic [2:0]  csr_idx = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        msg_valid, msg_ready = 1'b1;
  logic [31:0] msg_addr, msg_data;

  int n_chk = 0, n_bad = 0, hs = 0, cyc = 0;
  logic [31:0] hs_addr = '0, hs_data = '0;

  // behavioural reference state
  logic [10:0] m_s1 = '0, m_s2 = '0, m_s3 = '0, m_mask = '0, m_req = '0, m_pend = '0;
  logic [31:0] m_tgt = '0, m_rdata = '0, m_addr = '0, m_data = '0;
  logic        m_valid = 1'b0;

  always #10 clk = ~clk;

  bridge_irq_agg u_dut (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .csr_wr(csr_wr), .csr_rd(csr_rd),
    .csr_idx(csr_idx), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (msg_valid && msg_ready) begin
      hs++;
      hs_addr = msg_addr;
      hs_data = msg_data;
    end
    if (rst_n) begin
      logic [10:0] edges, unm;
      logic go;
      edges = m_s2 & ~m_s3;
      unm   = edges & m_mask & 11'h5FF;
      if (csr_rd) begin
        case (csr_idx)
          3'd0: m_rdata = {21'b0, m_req};
          3'd1: m_rdata = {21'b0, m_mask};
          3'd2: m_rdata = {21'b0, m_pend};
          3'd3: m_rdata = {21'b0, m_s2};
          3'd4: m_rdata = m_tgt;
          default: m_rdata = 0;
        endcase
      end
      m_req  = ((csr_rd && csr_idx == 3'd0) ? 11'd0 : m_req) | unm;
      m_pend = ((csr_rd && csr_idx == 3'd2) ? 11'd0 : m_pend) | edges;
      go = (unm != 0) || (csr_wr && csr_idx == 3'd5);
      if (go && (!m_valid || msg_ready)) begin
        m_valid = 1'b1;
        m_addr = m_tgt & 32'hFFFF_FFE0;
        m_data = m_tgt & 32'h1F;
      end else if (msg_ready) m_valid = 1'b0;
      if (csr_wr && csr_idx == 3'd1) m_mask = csr_wdata[10:0];
      if (csr_wr && csr_idx == 3'd4) m_tgt = csr_wdata;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = src_irq;
    end
  end

  always @(negedge clk) if (rst_n) begin
    check("R8 model valid", {31'b0, msg_valid}, {31'b0, m_valid});
    if (m_valid) begin
      check("R8 model addr", msg_addr, m_addr);
      check("R8 model data", msg_data, m_data);
    end
    check("R11 model rdata", csr_rdata, m_rdata);
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); csr_wr = 1'b1; csr_idx = a; csr_wdata = d;
    @(negedge clk); csr_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); csr_rd = 1'b1; csr_idx = a;
    @(negedge clk); csr_rd = 1'b0;
    check(tag, csr_rdata, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected<20000", cyc);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check("R1 valid after reset", {31'b0, msg_valid}, 32'd0);
    rd(3'd1, 32'd0, "R1 mask reset");
    rd(3'd4, 32'd0, "R1 target reset");
    rd(3'd0, 32'd0, "R1 request reset");
    rd(3'd2, 32'd0, "R1 pending reset");

    wr(3'd4, 32'hABCD_E013);
    wr(3'd1, 32'h7FF);
    src_irq[0] = 1'b1; idle(6);
    check("R8 one delivery", hs, 1);
    check("R8 address", hs_addr, 32'hABCD_E000);
    check("R8 data", hs_data, 32'h13);
    rd(3'd0, 32'h001, "R3 edge latched");
    rd(3'd0, 32'h000, "R6 read cleared");
    rd(3'd3, 32'h001, "R2 level");
    rd(3'd2, 32'h001, "R7 pending");
    rd(3'd3, 32'h001, "R7 level unchanged by pending read");

    wr(3'd1, 32'h0);
    src_irq[1] = 1'b1; src_irq[2] = 1'b1; idle(6);
    check("R4 masked no delivery", hs, 1);
    wr(3'd1, 32'h002); idle(4);
    rd(3'd0, 32'h000, "R3 high-at-unmask no request");
    check("R3 high-at-unmask no delivery", hs, 1);
    rd(3'd2, 32'h006, "R7 pending ignores mask");

    wr(3'd1, 32'h7FF);
    src_irq[9] = 1'b1; idle(6);
    rd(3'd0, 32'h000, "R5 bit9 reads zero");
    check("R5 bit9 no delivery", hs, 1);
    src_irq[8] = 1'b1; idle(6);
    check("R5 bit8 delivers", hs, 2);
    rd(3'd0, 32'h100, "R5 bit8 latched");

    msg_ready = 1'b0;
    src_irq[3] = 1'b1; idle(6);
    check("R9 waiting valid", {31'b0, msg_valid}, 32'd1);
    src_irq[4] = 1'b1; idle(6);
    check("R9 no completion while stalled", hs, 2);
    msg_ready = 1'b1; idle(3);
    check("R9 merged single write", hs, 3);
    rd(3'd0, 32'h018, "R9 both requests latched");

    wr(3'd4, 32'h1234_5607);
    wr(3'd5, 32'h0); idle(3);
    check("R10 retrigger delivers once", hs, 4);
    check("R10 address", hs_addr, 32'h1234_5600);
    check("R10 data", hs_data, 32'h07);

    src_irq[6] = 1'b1; idle(6);
    check("R3 bit6 delivered", hs, 5);
    @(negedge clk); src_irq[5] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); csr_rd = 1'b1; csr_idx = 3'd0;
    @(negedge clk); csr_rd = 1'b0;
    check("R6 read returns old bits", csr_rdata, 32'h040);
    rd(3'd0, 32'h020, "R6 same-cycle edge kept");

    rd(3'd6, 32'd0, "R11 unused index");
    rd(3'd3, {21'b0, src_irq}, "R2 level all");
    idle(4);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule